// File: doc/BRIEF.md
# Snooping Write-Broadcast Cache Controller with Write-Run Ownership

This block is the private cache controller that sits between one processor and a shared bus in a bus-based multiprocessor. It is direct-mapped with one-word lines. Every line carries one of four states: Invalid, Readable (a shared, clean copy), First-write (this processor made the most recent write, and that write went out on the bus), and Local (exclusive, dirty, served without bus traffic). The controller watches every foreign bus transaction on its snoop port. A foreign write does not destroy the copies in other caches: every cache whose line carries that address takes the broadcast data and keeps a Readable copy.

Exclusive ownership is granted only when one processor writes the same address several times in a row. Each line keeps a run counter. The first write from a shared or missing line goes out as an ordinary bus write and leaves the line in First-write. When a write brings the run to the threshold (parameter `WR_THRESH`, default 2), the controller issues a dedicated bus invalidate instead of a write and takes the line to Local. Any snooped foreign reference to the address clears the run. If a Local owner snoops a foreign read, it aborts that read, places its dirty word on the write-back lines, and drops to Readable so that the retried read sees the correct value.

The environment supplies one bus transaction per cycle. The snoop port carries only other agents' transactions, and a foreign transaction never completes in the same cycle as a grant to this cache. The CPU holds its request and operands stable until it receives the acknowledge.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_ack` and `snp_kill` are low. The first read of any address therefore goes to the bus.
- R2: A CPU read that hits a line in Readable, First-write or Local state returns the line's data with `cpu_ack` high in the cycle after the request is first sampled, and makes no bus request. `cpu_ack` is a one-cycle pulse.
- R3: A CPU read miss, or a read that finds the tag in Invalid state, issues a bus read (`bus_op` = 0) at the CPU address. On grant it returns `bus_rdata` to the CPU and keeps it as a Readable line.
- R4: A CPU write to a line that is missing, Invalid or Readable issues a bus write (`bus_op` = 1) carrying the CPU data and leaves the line in First-write with a run count of 1.
- R5: The write that brings the uninterrupted run to `WR_THRESH` issues a bus invalidate (`bus_op` = 2) and makes the line Local. Further CPU writes to a Local line make no bus request.
- R6: A snooped foreign read or write whose address matches the line clears its run count. The next CPU write to that address is then a bus write, not an invalidate.
- R7: A snooped, non-aborted foreign write (`snp_op` = 1) whose address matches the line's tag stores `snp_data` and makes the line Readable, whatever its state, including First-write and Local.
- R8: A snooped foreign read (`snp_op` = 0) that hits a Local line raises `snp_kill` in the same cycle, with the line's data on `snp_wb_data`, and the line becomes Readable.
- R9: A snooped, non-aborted foreign read that matches an Invalid or Readable line stores `snp_data` as a Readable copy. A First-write line keeps its state and data. A snooped transaction with `snp_abort` high is ignored by every line that is not Local.
- R10: A snooped, non-aborted invalidate (`snp_op` = 2) that matches the line makes it Invalid.
- R11: A miss that replaces a Local line first issues a bus write of the old address and data, then the requested operation. Replacing a line in Invalid, Readable or First-write state issues no write-back.
- R12: A bus grant that comes with `bus_abort` is retried. The line state and the run count do not change until a grant arrives without `bus_abort`.
- R13: Once raised, `bus_req` stays high until a grant.
- R14: A snooped transaction whose tag differs from the line's tag changes nothing and never raises `snp_kill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until acknowledge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus transaction request |
| bus_op | output | 2 | 0 read, 1 write, 2 invalidate |
| bus_addr | output | 8 | Bus transaction address |
| bus_wdata | output | 16 | Bus write data |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_abort | input | 1 | Granted transaction was aborted; retry |
| bus_rdata | input | 16 | Read data, valid with grant |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_op | input | 2 | Foreign operation, same coding as `bus_op` |
| snp_addr | input | 8 | Foreign address |
| snp_data | input | 16 | Written data, or data returned to a foreign read |
| snp_abort | input | 1 | The foreign transaction was aborted |
| snp_kill | output | 1 | Abort the foreign read; owner write-back follows |
| snp_wb_data | output | 16 | Owner's data, valid with `snp_kill` |

## Verification
The bench walks every line index through misses, hits, write runs, owner aborts and evictions, and predicts each bus transaction from a memory model of its own. It targets the run counter. A controller that does not clear the count on snooped traffic would invalidate after an interrupted run, and one that counts a retried grant would reach ownership a write early. Both show up as a wrong `bus_op`. It also checks that a demoted First-write holder really takes broadcast data: a design that ignores it would serve a stale word on a read hit. It checks that aborted snoops and snoops with a different tag leave lines untouched, and that eviction writes back only dirty Local lines. A wrong eviction shows up as an extra or a missing bus write.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int NLINES = 1 << IDX_W;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_RDB = 2'd1,
        LN_FW  = 2'd2,
        LN_LOC = 2'd3
    } ln_st_t;

    typedef enum logic [1:0] {
        BOP_RD  = 2'd0,
        BOP_WR  = 2'd1,
        BOP_INV = 2'd2
    } bop_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        ln_st_t            st;
        logic [CNT_W-1:0]  cnt;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/wbc_store.sv
module wbc_store
    import wbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_t            sw_line,
    input  logic             cw_en,
    input  logic [IDX_W-1:0] cw_idx,
    input  line_t            cw_line,
    input  logic [IDX_W-1:0] s_idx,
    input  logic [IDX_W-1:0] c_idx,
    output line_t            s_line,
    output line_t            c_line
);
    line_t lines [NLINES];

    // Snoop updates take precedence on a shared index.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[g] <= '0;
            end else if (sw_en && sw_idx == IDX_W'(g)) begin
                lines[g] <= sw_line;
            end else if (cw_en && cw_idx == IDX_W'(g)) begin
                lines[g] <= cw_line;
            end
        end
    end

    assign s_line = lines[s_idx];
    assign c_line = lines[c_idx];
endmodule

// File: rtl/wbc_snoop.sv
module wbc_snoop
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              snp_abort,
    input  line_t             cur,
    output logic              upd_en,
    output line_t             upd_line,
    output logic              kill,
    output logic [DATA_W-1:0] wb_data
);
    logic hit;

    always_comb begin
        hit      = snp_valid && (cur.tag == tag_of(snp_addr));
        upd_en   = 1'b0;
        upd_line = cur;
        kill     = 1'b0;
        wb_data  = cur.data;
        if (hit) begin
            case (bop_t'(snp_op))
                BOP_RD: begin
                    if (cur.st == LN_LOC) begin
                        kill         = 1'b1;
                        upd_en       = 1'b1;
                        upd_line.st  = LN_RDB;
                        upd_line.cnt = '0;
                    end else if (!snp_abort) begin
                        upd_en       = 1'b1;
                        upd_line.cnt = '0;
                        if (cur.st != LN_FW) begin
                            upd_line.data = snp_data;
                            upd_line.st   = LN_RDB;
                        end
                    end
                end
                BOP_WR: begin
                    if (!snp_abort) begin
                        upd_en        = 1'b1;
                        upd_line.data = snp_data;
                        upd_line.st   = LN_RDB;
                        upd_line.cnt  = '0;
                    end
                end
                BOP_INV: begin
                    if (!snp_abort) begin
                        upd_en       = 1'b1;
                        upd_line.st  = LN_INV;
                        upd_line.cnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R8
    owner_demote_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_op == 2'd0 && $past(snp_valid) && $past(snp_kill_q())
         && snp_addr == $past(snp_addr)) |-> !kill);

    function automatic logic snp_kill_q();
        return kill;
    endfunction
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int WR_THRESH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_t             cur,
    input  logic              snp_busy,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_abort,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wr_en,
    output line_t             wr_line
);
    typedef enum logic [1:0] {C_IDLE, C_BUS, C_ACK} cst_t;
    localparam logic [CNT_W-1:0] THR = CNT_W'(WR_THRESH);

    cst_t              st_q, st_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [TAG_W-1:0]  tag;
    logic              hit, need_wb, reach, done;
    logic [CNT_W-1:0]  base_cnt, nxt_cnt;
    bop_t              op;

    always_comb begin
        tag      = tag_of(cpu_addr);
        hit      = (cur.tag == tag) && (cur.st != LN_INV);
        need_wb  = (cur.tag != tag) && (cur.st == LN_LOC);
        base_cnt = (hit && cur.st == LN_FW) ? cur.cnt : '0;
        nxt_cnt  = base_cnt + CNT_W'(1);
        reach    = nxt_cnt >= THR;
        done     = bus_gnt && !bus_abort;
        st_d      = st_q;
        rdata_d   = rdata_q;
        wr_en     = 1'b0;
        wr_line   = cur;
        bus_req   = 1'b0;
        op        = BOP_RD;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        cpu_ack   = 1'b0;
        case (st_q)
            C_IDLE: begin
                if (cpu_req && !snp_busy) begin
                    if (!cpu_we && hit) begin
                        rdata_d = cur.data;
                        st_d    = C_ACK;
                    end else if (cpu_we && hit && cur.st == LN_LOC) begin
                        wr_en        = 1'b1;
                        wr_line.data = cpu_wdata;
                        st_d         = C_ACK;
                    end else begin
                        st_d = C_BUS;
                    end
                end
            end
            C_BUS: begin
                bus_req = 1'b1;
                if (need_wb) begin
                    op        = BOP_WR;
                    bus_addr  = {cur.tag, idx_of(cpu_addr)};
                    bus_wdata = cur.data;
                    if (done) begin
                        wr_en       = 1'b1;
                        wr_line.tag = tag;
                        wr_line.st  = LN_INV;
                        wr_line.cnt = '0;
                    end
                end else if (!cpu_we) begin
                    op = BOP_RD;
                    if (done) begin
                        wr_en        = 1'b1;
                        wr_line.tag  = tag;
                        wr_line.data = bus_rdata;
                        wr_line.st   = LN_RDB;
                        wr_line.cnt  = '0;
                        rdata_d      = bus_rdata;
                        st_d         = C_ACK;
                    end
                end else begin
                    op = reach ? BOP_INV : BOP_WR;
                    if (done) begin
                        wr_en        = 1'b1;
                        wr_line.tag  = tag;
                        wr_line.data = cpu_wdata;
                        wr_line.st   = reach ? LN_LOC : LN_FW;
                        wr_line.cnt  = nxt_cnt;
                        st_d         = C_ACK;
                    end
                end
            end
            default: begin
                cpu_ack = 1'b1;
                st_d    = C_IDLE;
            end
        endcase
    end

    assign bus_op    = op;
    assign cpu_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= C_IDLE;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);
    // R12
    abort_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && bus_abort) |=> bus_req);
    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);
    // R5
    inv_from_fw_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == 2'd2) |-> (cpu_we && cur.st == LN_FW));
    // R11
    wb_then_op_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && !bus_abort && bus_addr != cpu_addr) |=> bus_req);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int WR_THRESH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic        cpu_ack,
    output logic [15:0] cpu_rdata,
    output logic        bus_req,
    output logic [1:0]  bus_op,
    output logic [7:0]  bus_addr,
    output logic [15:0] bus_wdata,
    input  logic        bus_gnt,
    input  logic        bus_abort,
    input  logic [15:0] bus_rdata,
    input  logic        snp_valid,
    input  logic [1:0]  snp_op,
    input  logic [7:0]  snp_addr,
    input  logic [15:0] snp_data,
    input  logic        snp_abort,
    output logic        snp_kill,
    output logic [15:0] snp_wb_data
);
    line_t s_line, c_line, sw_line, cw_line;
    logic  sw_en, cw_en, snp_busy;

    assign snp_busy = snp_valid && (idx_of(snp_addr) == idx_of(cpu_addr));

    wbc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .sw_en   (sw_en),
        .sw_idx  (idx_of(snp_addr)),
        .sw_line (sw_line),
        .cw_en   (cw_en),
        .cw_idx  (idx_of(cpu_addr)),
        .cw_line (cw_line),
        .s_idx   (idx_of(snp_addr)),
        .c_idx   (idx_of(cpu_addr)),
        .s_line  (s_line),
        .c_line  (c_line)
    );

    wbc_snoop u_snoop (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_op    (snp_op),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .snp_abort (snp_abort),
        .cur       (s_line),
        .upd_en    (sw_en),
        .upd_line  (sw_line),
        .kill      (snp_kill),
        .wb_data   (snp_wb_data)
    );

    wbc_ctrl #(.WR_THRESH(WR_THRESH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .cur       (c_line),
        .snp_busy  (snp_busy),
        .bus_req   (bus_req),
        .bus_op    (bus_op),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_gnt   (bus_gnt),
        .bus_abort (bus_abort),
        .bus_rdata (bus_rdata),
        .wr_en     (cw_en),
        .wr_line   (cw_line)
    );

    // R14
    tag_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && s_line.tag != tag_of(snp_addr)) |-> !snp_kill);
endmodule

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0, bus_abort = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0, snp_abort = 1'b0;
    logic [1:0]  snp_op = '0;
    logic [7:0]  snp_addr = '0;
    logic [15:0] snp_data = '0;
    logic        snp_kill;
    logic [15:0] snp_wb_data;

    always #2.5 clk = ~clk;

    wbc_cache u_wbc_cache (.*);

    int          total = 0, bad = 0;
    logic [15:0] mem [256];
    int          nops, natt, ncyc;
    logic [1:0]  op_log [4];
    logic [7:0]  adr_log [4];
    logic [15:0] dat_log [4];
    logic [15:0] got;
    logic        kill_s;
    logic [15:0] wbd_s;

    localparam logic [7:0] A = 8'h0D;
    localparam logic [7:0] B = 8'h0E;

    function automatic logic [15:0] init_val(input int a);
        return 16'h1000 + 16'(a * 7);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d, input int aborts);
        int left;
        bit done;
        left = aborts;
        done = 1'b0;
        nops = 0; natt = 0; ncyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        for (int i = 0; i < 60 && !done; i++) begin
            @(negedge clk);
            ncyc++;
            bus_gnt = 1'b0; bus_abort = 1'b0;
            if (cpu_ack) begin
                got = cpu_rdata;
                done = 1'b1;
            end else if (bus_req) begin
                natt++;
                bus_gnt = 1'b1;
                if (left > 0) begin
                    left--;
                    bus_abort = 1'b1;
                end else begin
                    if (nops < 4) begin
                        op_log[nops] = bus_op; adr_log[nops] = bus_addr; dat_log[nops] = bus_wdata;
                    end
                    nops++;
                    bus_rdata = mem[bus_addr];
                    if (bus_op == 2'd1) mem[bus_addr] = bus_wdata;
                end
            end
        end
        cpu_req = 1'b0;
        if (!done) chk("R13 cpu op timeout", 0, 1);
    endtask

    task automatic snoop(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d, input logic ab);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a; snp_data = d; snp_abort = ab;
        #1;
        kill_s = snp_kill;
        wbd_s  = snp_wb_data;
        if (kill_s) mem[a] = wbd_s;
        if (op == 2'd1 && !ab) mem[a] = d;
        @(negedge clk);
        snp_valid = 1'b0; snp_abort = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        chk("watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R1 cpu_ack after reset", cpu_ack, 0);
        chk("R1 snp_kill after reset", snp_kill, 0);
        cpu_op(1'b0, 8'h05, 16'h0, 0);
        chk("R1 first read goes to bus", nops, 1);
        chk("R3 read data", got, init_val(5));

        // sweep every index: miss then hit
        for (int k = 0; k < 4; k++) begin
            cpu_op(1'b0, 8'h0C + 8'(k), 16'h0, 0);
            chk("R3 miss ops (R11 no write-back of clean)", nops, 1);
            chk("R3 miss op code", op_log[0], 0);
            chk("R3 miss addr", adr_log[0], 8'h0C + 8'(k));
            chk("R3 miss data", got, init_val(12 + k));
            cpu_op(1'b0, 8'h0C + 8'(k), 16'h0, 0);
            chk("R2 hit no bus", nops, 0);
            chk("R2 hit latency", ncyc, 1);
            chk("R2 hit data", got, init_val(12 + k));
        end

        // write run to ownership
        cpu_op(1'b1, A, 16'hA001, 0);
        chk("R4 first write ops", nops, 1);
        chk("R4 first write code", op_log[0], 1);
        chk("R4 first write data", dat_log[0], 16'hA001);
        cpu_op(1'b1, A, 16'hA002, 0);
        chk("R5 second write invalidates", op_log[0], 2);
        cpu_op(1'b1, A, 16'hA003, 0);
        chk("R5 local write silent", nops, 0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R2 local read data", got, 16'hA003);

        // owner hit by foreign read
        snoop(2'd0, A, mem[A], 1'b0);
        chk("R8 kill raised", kill_s, 1);
        chk("R8 write-back data", wbd_s, 16'hA003);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R8 readable keeps data", got, 16'hA003);
        chk("R8 readable read no bus", nops, 0);
        cpu_op(1'b1, A, 16'hA004, 0);
        chk("R8 demoted write goes to bus", op_log[0], 1);

        // run cleared by foreign read
        snoop(2'd0, A, mem[A], 1'b0);
        chk("R6 no kill on first-write", kill_s, 0);
        cpu_op(1'b1, A, 16'hA005, 0);
        chk("R6 write after foreign read", op_log[0], 1);
        cpu_op(1'b1, A, 16'hA006, 0);
        chk("R5 run completes", op_log[0], 2);

        // broadcast capture
        snoop(2'd1, A, 16'hB001, 1'b0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R7 local captures broadcast", got, 16'hB001);
        chk("R7 capture read no bus", nops, 0);
        cpu_op(1'b1, A, 16'hA007, 0);
        chk("R7 captured line is readable", op_log[0], 1);
        snoop(2'd1, A, 16'hB002, 1'b0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R7 first-write holder captures", got, 16'hB002);
        cpu_op(1'b1, A, 16'hA008, 0);
        chk("R6 write after foreign write", op_log[0], 1);

        // invalidate
        snoop(2'd2, A, 16'h0, 1'b0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R10 read after invalidate ops", nops, 1);
        chk("R10 read after invalidate data", got, 16'hA008);

        // foreign tag at same index
        snoop(2'd1, 8'h3D, 16'hB003, 1'b0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R14 other tag write ignored", got, 16'hA008);
        cpu_op(1'b1, A, 16'hA009, 0);
        cpu_op(1'b1, A, 16'hA00A, 0);
        chk("R5 ownership again", op_log[0], 2);
        snoop(2'd0, 8'h3D, 16'h0, 1'b0);
        chk("R14 other tag read no kill", kill_s, 0);
        cpu_op(1'b0, A, 16'h0, 0);
        chk("R14 owner untouched", nops, 0);

        // snooped reads on clean holders
        snoop(2'd0, B, 16'hC001, 1'b1);
        cpu_op(1'b0, B, 16'h0, 0);
        chk("R9 aborted snoop ignored", got, init_val(14));
        snoop(2'd0, B, 16'hC002, 1'b0);
        cpu_op(1'b0, B, 16'h0, 0);
        chk("R9 readable captures read data", got, 16'hC002);
        snoop(2'd2, B, 16'h0, 1'b0);
        snoop(2'd0, B, 16'hC003, 1'b0);
        cpu_op(1'b0, B, 16'h0, 0);
        chk("R9 invalid holder captures", got, 16'hC003);
        chk("R9 capture no bus", nops, 0);

        // eviction
        cpu_op(1'b0, 8'h01, 16'h0, 0);
        chk("R11 dirty eviction ops", nops, 2);
        chk("R11 write-back code", op_log[0], 1);
        chk("R11 write-back addr", adr_log[0], A);
        chk("R11 write-back data", dat_log[0], 16'hA00A);
        chk("R11 then read code", op_log[1], 0);
        chk("R11 then read addr", adr_log[1], 8'h01);
        chk("R11 read data", got, init_val(1));
        cpu_op(1'b1, 8'h0B, 16'hA00B, 0);
        cpu_op(1'b0, 8'h0F, 16'h0, 0);
        chk("R11 first-write eviction no write-back", nops, 1);

        // aborted grants
        cpu_op(1'b0, 8'h02, 16'h0, 2);
        chk("R12 read attempts", natt, 3);
        chk("R12 read completes once", nops, 1);
        chk("R12 read data", got, init_val(2));
        cpu_op(1'b1, 8'h03, 16'hA00C, 1);
        chk("R12 write attempts", natt, 2);
        chk("R12 write code", op_log[0], 1);
        cpu_op(1'b1, 8'h03, 16'hA00D, 0);
        chk("R12 abort did not advance run", op_log[0], 2);
        cpu_op(1'b0, 8'h03, 16'h0, 0);
        chk("R12 owned data", got, 16'hA00D);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule